// File: doc/BRIEF.md
# Region Ownership Arbiter for Deterministic Shared Memory

This block keeps a sharing record for a small set of memory regions, each a line or a page, used by a group of threads that must talk to each other in the same order on every run. Every region is untouched, privately held by one thread, or shared for reading. A thread that presents an access gets one of three answers. Grant means the access goes ahead now. Stall means it must wait. Nack means it was refused and must not be retried until the thread holds the token.

Accesses that leave the record unchanged never wait. These are a thread touching a region it already holds privately, and any thread reading a shared region. Any access that would change the record is allowed only at a serialized point. At that point the requesting thread holds the token and every other thread is blocked. Only then is the record updated. A requester that holds the token while other threads are still running gets a stall response in every cycle until they are all blocked. A requester without the token gets a nack and the record is left alone. Each response comes one cycle after the request and carries the region's entry as it stands after the decision.

Top module: `region_owner_arbiter`

## Requirements
- R1: After reset every region reads as untouched (state code 2'b00, owner field 0), and no response strobe is raised while reset is held.
- R2: An access of either kind by the thread that privately owns the region (state 2'b01, owner field equal to the requester) is granted without the token and leaves the entry unchanged.
- R3: A read of a region in the shared state (2'b10) is granted to any thread without the token and leaves the entry unchanged.
- R4: A state-changing access from a thread that does not hold the token is answered with nack, and the table is left unchanged. State-changing accesses are: any access to an untouched region, a write to a shared region, and any access to a region another thread owns.
- R5: A state-changing access made while the token is held but other threads still run is answered with stall. It leaves the table unchanged and is answered again in every cycle it stays asserted. It is granted in the first cycle the other threads are all blocked.
- R6: A write granted at a serialized point leaves the region private (2'b01) with the writer as owner, whatever its previous state.
- R7: A read of an untouched region granted at a serialized point makes the reader its private owner.
- R8: A read of a region another thread owns, granted at a serialized point, moves the region to shared (2'b10) with the owner field cleared to 0.
- R9: A response strobe lasts one cycle, comes exactly one cycle after each cycle with a valid request and at no other time, and raises exactly one of grant, stall and nack. The response reports the entry as it stands after the decision.
- R10: An update changes only the addressed region's entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request present this cycle |
| reqThread | input | $clog2(NUM_THREADS) | Requesting thread id |
| reqRegion | input | $clog2(NUM_REGIONS) | Region index |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| tokenHeld | input | 1 | Requester holds the deterministic token |
| othersBlocked | input | 1 | All other threads are blocked waiting for the token |
| rspValid | output | 1 | One-cycle response strobe |
| rspGrant | output | 1 | Access may proceed |
| rspStall | output | 1 | Access must wait, retry next cycle |
| rspNack | output | 1 | Access refused, needs the token |
| rspState | output | 2 | Region state after the decision |
| rspOwner | output | $clog2(NUM_THREADS) | Owner field after the decision |

## Verification
The bench follows one region through every transition: untouched to private, private to shared, shared to private, and private from one owner to another. A design that updated the record at a refused access would show a changed entry on a later probe. A stall held over several cycles checks that the wait is answered every cycle and is released only when the other threads block; a design that granted early, or answered only once, fails here. Probing neighbouring regions after updates catches an entry write that decodes the wrong index, and an idle stretch catches a strobe that lingers or fires with no request.

// File: rtl/stab_pkg.sv
package stab_pkg;

  typedef enum logic [1:0] {
    ST_UNTOUCHED = 2'b00,
    ST_PRIVATE   = 2'b01,
    ST_SHARED    = 2'b10
  } regionState_e;

  // strobes from the decision logic to the table datapath
  typedef struct packed {
    logic         commit;
    logic         grant;
    logic         stall;
    logic         nack;
    logic         setOwner;
    regionState_e nextState;
  } ctrlStb_t;

endpackage

// File: rtl/stab_ctrl.sv
module stab_ctrl
  import stab_pkg::*;
#(
  parameter int TW = 2
) (
  input  logic          reqValid,
  input  logic [TW-1:0] reqThread,
  input  logic          reqWrite,
  input  logic          tokenHeld,
  input  logic          othersBlocked,
  input  regionState_e  curState,
  input  logic [TW-1:0] curOwner,
  output ctrlStb_t      stb
);

  logic ownHit;
  logic freeAccess;
  logic serialPoint;

  assign ownHit      = (curState == ST_PRIVATE) && (curOwner == reqThread);
  assign freeAccess  = ownHit || ((curState == ST_SHARED) && !reqWrite);
  assign serialPoint = tokenHeld && othersBlocked;

  always_comb begin
    stb = '{commit: 1'b0, grant: 1'b0, stall: 1'b0, nack: 1'b0,
            setOwner: 1'b0, nextState: curState};
    if (reqValid) begin
      if (freeAccess) begin
        stb.grant = 1'b1;
      end else if (serialPoint) begin
        stb.grant  = 1'b1;
        stb.commit = 1'b1;
        if (reqWrite || curState == ST_UNTOUCHED) begin
          stb.nextState = ST_PRIVATE;
          stb.setOwner  = 1'b1;
        end else begin
          stb.nextState = ST_SHARED;
        end
      end else if (tokenHeld) begin
        stb.stall = 1'b1;
      end else begin
        stb.nack = 1'b1;
      end
    end
  end

endmodule

// File: rtl/stab_table.sv
module stab_table
  import stab_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int TW = 2,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [TW-1:0] reqThread,
  input  logic [RW-1:0] reqRegion,
  input  ctrlStb_t      stb,
  output regionState_e  curState,
  output logic [TW-1:0] curOwner,
  output logic          rspValid,
  output logic          rspGrant,
  output logic          rspStall,
  output logic          rspNack,
  output logic [1:0]    rspState,
  output logic [TW-1:0] rspOwner
);

  localparam int ENTRY_W = 2 + TW;

  regionState_e  stateQ [NUM_REGIONS];
  logic [TW-1:0] ownerQ [NUM_REGIONS];
  logic [NUM_REGIONS*ENTRY_W-1:0] tableFlat;
  logic [TW-1:0] newOwner;

  assign newOwner = stb.setOwner ? reqThread : '0;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stateQ[g] <= ST_UNTOUCHED;
        ownerQ[g] <= '0;
      end else if (stb.commit && reqRegion == RW'(g)) begin
        stateQ[g] <= stb.nextState;
        ownerQ[g] <= newOwner;
      end
    end
    assign tableFlat[g*ENTRY_W +: ENTRY_W] = {stateQ[g], ownerQ[g]};
  end

  assign curState = stateQ[reqRegion];
  assign curOwner = ownerQ[reqRegion];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspGrant <= 1'b0;
      rspStall <= 1'b0;
      rspNack  <= 1'b0;
      rspState <= ST_UNTOUCHED;
      rspOwner <= '0;
    end else begin
      rspValid <= stb.grant | stb.stall | stb.nack;
      rspGrant <= stb.grant;
      rspStall <= stb.stall;
      rspNack  <= stb.nack;
      rspState <= stb.commit ? stb.nextState : curState;
      rspOwner <= stb.commit ? newOwner : curOwner;
    end
  end

  // refused requests must leave the whole table untouched
  assert_refusal_keeps_table_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.nack || stb.stall) |=> $stable(tableFlat));

  assert_single_outcome_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $onehot({rspGrant, rspStall, rspNack}));

  assert_outcome_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !(rspGrant || rspStall || rspNack));

endmodule

// File: rtl/region_owner_arbiter.sv
module region_owner_arbiter
  import stab_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_REGIONS = 8,
  localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int RW = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [TW-1:0] reqThread,
  input  logic [RW-1:0] reqRegion,
  input  logic          reqWrite,
  input  logic          tokenHeld,
  input  logic          othersBlocked,
  output logic          rspValid,
  output logic          rspGrant,
  output logic          rspStall,
  output logic          rspNack,
  output logic [1:0]    rspState,
  output logic [TW-1:0] rspOwner
);

  ctrlStb_t      stb;
  regionState_e  curState;
  logic [TW-1:0] curOwner;

  stab_ctrl #(.TW(TW)) u_ctrl (
    .reqValid      (reqValid),
    .reqThread     (reqThread),
    .reqWrite      (reqWrite),
    .tokenHeld     (tokenHeld),
    .othersBlocked (othersBlocked),
    .curState      (curState),
    .curOwner      (curOwner),
    .stb           (stb)
  );

  stab_table #(.NUM_REGIONS(NUM_REGIONS), .TW(TW), .RW(RW)) u_table (
    .clk       (clk),
    .rstN      (rstN),
    .reqThread (reqThread),
    .reqRegion (reqRegion),
    .stb       (stb),
    .curState  (curState),
    .curOwner  (curOwner),
    .rspValid  (rspValid),
    .rspGrant  (rspGrant),
    .rspStall  (rspStall),
    .rspNack   (rspNack),
    .rspState  (rspState),
    .rspOwner  (rspOwner)
  );

  assert_strobe_after_request_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid));

  assert_stall_only_with_token_R5: assert property (@(posedge clk) disable iff (!rstN)
    rspStall |-> ($past(tokenHeld) && !$past(othersBlocked)));

  assert_nack_only_without_token_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspNack |-> !$past(tokenHeld));

  assert_grant_not_untouched_R7: assert property (@(posedge clk) disable iff (!rstN)
    rspGrant |-> (rspState != 2'b00));

endmodule

// File: tb/tb_region_owner_arbiter.sv
module tb_region_owner_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int GRANT = 0, STALL = 1, NACK = 2, NONE = 4;

  logic       clk = 1'b0;
  logic       rstN;
  logic       reqValid, reqWrite, tokenHeld, othersBlocked;
  logic [1:0] reqThread;
  logic [2:0] reqRegion;
  logic       rspValid, rspGrant, rspStall, rspNack;
  logic [1:0] rspState;
  logic [1:0] rspOwner;

  int vectors = 0;
  int misses  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_owner_arbiter dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqThread(reqThread),
    .reqRegion(reqRegion), .reqWrite(reqWrite), .tokenHeld(tokenHeld),
    .othersBlocked(othersBlocked), .rspValid(rspValid), .rspGrant(rspGrant),
    .rspStall(rspStall), .rspNack(rspNack), .rspState(rspState), .rspOwner(rspOwner)
  );

  function automatic int outcome();
    if (!rspValid) return (rspGrant || rspStall || rspNack) ? 3 : NONE;
    if (rspGrant && !rspStall && !rspNack) return GRANT;
    if (rspStall && !rspGrant && !rspNack) return STALL;
    if (rspNack && !rspGrant && !rspStall) return NACK;
    return 3;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one request, sampled after the edge that registers its response
  task automatic access(input int th, input int rg, input bit wr, input bit tok,
                        input bit blk, input int expCode, input int expSt,
                        input int expOw, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqThread = 2'(th); reqRegion = 3'(rg);
    reqWrite = wr; tokenHeld = tok; othersBlocked = blk;
    @(posedge clk); #2;
    check({tag, " outcome"}, outcome(), expCode);
    check({tag, " state"}, int'(rspState), expSt);
    check({tag, " owner"}, int'(rspOwner), expOw);
    @(negedge clk);
    reqValid = 1'b0; tokenHeld = 1'b0; othersBlocked = 1'b0;
  endtask

  // side-effect-free look at an entry: token held, others running, read
  task automatic probe(input int rg, input int expSt, input int expOw, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqThread = 2'd0; reqRegion = 3'(rg);
    reqWrite = 1'b0; tokenHeld = 1'b1; othersBlocked = 1'b0;
    @(posedge clk); #2;
    check({tag, " probe state"}, int'(rspState), expSt);
    check({tag, " probe owner"}, int'(rspOwner), expOw);
    @(negedge clk);
    reqValid = 1'b0; tokenHeld = 1'b0;
  endtask

  task automatic test_reset();
    reqValid = 1'b0; reqWrite = 1'b0; tokenHeld = 1'b0; othersBlocked = 1'b0;
    reqThread = '0; reqRegion = '0;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #2 check("R1 strobe during reset", outcome(), NONE);
    @(negedge clk) rstN = 1'b1;
    for (int r = 0; r < 8; r++) probe(r, 0, 0, "R1 reset entry");
  endtask

  task automatic test_first_read();
    access(1, 2, 0, 0, 0, NACK, 0, 0, "R4 untouched read no token");
    probe(2, 0, 0, "R4 untouched after nack");
    access(1, 2, 0, 1, 1, GRANT, 1, 1, "R7 first read serial");
  endtask

  task automatic test_owner_free();
    access(1, 2, 1, 0, 0, GRANT, 1, 1, "R2 owner write no token");
    access(1, 2, 0, 0, 0, GRANT, 1, 1, "R2 owner read no token");
  endtask

  task automatic test_stall_then_share();
    access(2, 2, 0, 0, 0, NACK, 1, 1, "R4 foreign read no token");
    @(negedge clk);
    reqValid = 1'b1; reqThread = 2'd2; reqRegion = 3'd2;
    reqWrite = 1'b0; tokenHeld = 1'b1; othersBlocked = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); #2;
      check("R5 held stall outcome", outcome(), STALL);
      check("R5 held stall state", int'(rspState), 1);
    end
    @(negedge clk) othersBlocked = 1'b1;
    @(posedge clk); #2;
    check("R5 release grant", outcome(), GRANT);
    check("R8 shared state", int'(rspState), 2);
    check("R8 owner cleared", int'(rspOwner), 0);
    @(negedge clk);
    reqValid = 1'b0; tokenHeld = 1'b0; othersBlocked = 1'b0;
    @(posedge clk); #2;
    check("R9 strobe one cycle", outcome(), NONE);
  endtask

  task automatic test_shared_read();
    access(3, 2, 0, 0, 0, GRANT, 2, 0, "R3 shared read other thread");
    access(1, 2, 0, 0, 0, GRANT, 2, 0, "R3 shared read former owner");
  endtask

  task automatic test_writes();
    access(0, 2, 1, 0, 0, NACK, 2, 0, "R4 shared write no token");
    access(0, 2, 1, 1, 1, GRANT, 1, 0, "R6 shared write serial");
    access(3, 2, 1, 1, 1, GRANT, 1, 3, "R6 foreign write serial");
    access(2, 5, 1, 1, 1, GRANT, 1, 2, "R6 untouched write serial");
  endtask

  task automatic test_isolation();
    probe(2, 1, 3, "R10 region2");
    probe(5, 1, 2, "R10 region5");
    probe(4, 0, 0, "R10 region4");
    probe(6, 0, 0, "R10 region6");
  endtask

  task automatic test_idle();
    for (int c = 0; c < 4; c++) begin
      @(posedge clk); #2;
      check("R9 idle no strobe", outcome(), NONE);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    test_reset();
    test_first_read();
    test_owner_free();
    test_stall_then_share();
    test_shared_read();
    test_writes();
    test_isolation();
    test_idle();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    vectors++;
    misses++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

endmodule